// File: doc/BRIEF.md
# UART FIFO Interrupt and Status Controller

This block is the register-side control logic of one UART channel. It buffers received characters in a 16-entry receive queue and outgoing characters in a 16-entry transmit queue. It keeps the enable, control, interrupt-identification and line-status registers, and it drives a single interrupt line to the host. The receive shifter delivers a byte strobe with per-character parity, framing and break flags. The transmit shifter pulls bytes from the head of the transmit queue and reports when it is busy. Baud timing and serial shifting sit outside the block.

The host reaches the block through a small register port. Register 0 reads the receive queue and writes the transmit queue. Register 1 holds the enables. Register 2 returns the interrupt identification on a read and takes the control byte on a write. Register 3 returns the line status. When every enable bit is zero, the host can run the channel by polling the line status, which keeps updating in full.

Top module: `uart_fifo_irq_ctrl`

## Requirements
- R1: After reset, `irq` is 0, IER (address 1) reads 0x00, ISR (address 2) reads 0x01 and LSR (address 3) reads 0x60.
- R2: Control bits [7:6] select the receive trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. Bit 0 enables the queues and makes ISR bits [7:6] read 11. While IER bit 0 is set and the receive count is at or above the trigger level, `irq` is 1 and ISR[3:0] reads 0100.
- R3: The receive-data interrupt clears by itself in the cycle after a read brings the receive count below the trigger level.
- R4: LSR bit 0 is 1 whenever the receive queue holds a byte and 0 when it is empty. Reads of address 0 return the bytes in arrival order.
- R5: A byte that arrives while the receive queue holds 16 bytes is discarded and sets LSR bit 1 (overrun). A read of LSR clears that bit.
- R6: LSR bits 2, 3 and 4 show the parity, framing and break flags of the byte at the head of the receive queue. LSR bit 7 is 1 while any stored byte carries an error flag.
- R7: When a pull empties the transmit queue, a transmit-empty event is latched, and it shows as ISR[3:0] = 0010 with `irq` set while IER bit 1 is 1. The event is cleared by an ISR read that reports it, or by any write to address 0.
- R8: LSR bit 5 is 1 when the transmit queue is empty. LSR bit 6 is 1 only when the queue is empty and `tx_busy` is 0.
- R9: The ISR shows only the highest-priority pending source. Line status comes first (code 0110, IER bit 2, raised by overrun or by an error on the head byte), then receive data (0100), then transmit empty (0010). Code 0001 means nothing is pending.
- R10: With IER[3:0] = 0, `irq` stays 0, while LSR keeps reporting the data, overrun and transmit-empty states.
- R11: The transmit queue presents its head byte on `tx_byte`, with `tx_valid` set, in the order the bytes were written. Each `tx_pull` removes one byte.
- R12: Writing control bit 1 empties the receive queue and writing control bit 2 empties the transmit queue. Both flush bits clear themselves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (side effects occur at the clock edge) |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the addressed register |
| rx_strobe | input | 1 | A received byte is available |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error on the received byte |
| rx_ferr | input | 1 | Framing error on the received byte |
| rx_brk | input | 1 | Break detected on the received byte |
| tx_pull | input | 1 | The transmit shifter takes the head byte |
| tx_busy | input | 1 | The transmit shifter is still sending |
| tx_byte | output | 8 | Head byte of the transmit queue |
| tx_valid | output | 1 | The transmit queue is not empty |
| irq | output | 1 | Interrupt to the host |

## Verification
The bench walks the receive count across each of the four trigger levels. A design that compared with greater-than, or decoded the level field wrongly, would raise the interrupt one byte late or at the wrong fill. It overfills the receive queue to check that the seventeenth byte is lost and flagged, and that a second LSR read shows the flag gone. A design that stored the extra byte would return a wrong sequence, and one that cleared the flag too early or never would fail the second read. Error flags are placed on the second stored byte, so that a design reporting the tail byte's flags, or dropping the any-error bit too soon, shows wrong LSR values. The transmit-empty event is raised alongside a receive interrupt and then cleared both by a data write and by an ISR read. A mis-ordered priority or a clear that is too broad would show a wrong ISR code or a lost interrupt.

// File: rtl/uart_fifo_irq_ctrl.sv
module uart_fifo_irq_ctrl #(
  parameter int DEPTH  = 16,
  parameter int TRIG_B = 4,
  parameter int TRIG_C = 8,
  parameter int TRIG_D = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_wr,
  input  logic       cpu_rd,
  input  logic [2:0] cpu_addr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  input  logic       rx_strobe,
  input  logic [7:0] rx_byte,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       rx_brk,
  input  logic       tx_pull,
  input  logic       tx_busy,
  output logic [7:0] tx_byte,
  output logic       tx_valid,
  output logic       irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [2:0] A_DATA = 3'd0, A_IER = 3'd1, A_ISR = 3'd2, A_LSR = 3'd3;

  logic [10:0]   rx_mem [DEPTH];
  logic [7:0]    tx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp, tx_wp, tx_rp;
  logic [CW-1:0] rx_cnt, tx_cnt, err_cnt, trig;
  logic [3:0]    ier, isr_code;
  logic [1:0]    trig_sel;
  logic          fifo_en, ovr, tx_flag;

  wire wr_data  = cpu_wr && cpu_addr == A_DATA;
  wire wr_ier   = cpu_wr && cpu_addr == A_IER;
  wire wr_fcr   = cpu_wr && cpu_addr == A_ISR;
  wire rd_data  = cpu_rd && cpu_addr == A_DATA;
  wire rd_isr   = cpu_rd && cpu_addr == A_ISR;
  wire rd_lsr   = cpu_rd && cpu_addr == A_LSR;
  wire rx_flush = wr_fcr && cpu_wdata[1];
  wire tx_flush = wr_fcr && cpu_wdata[2];

  wire        rx_full  = rx_cnt == FULL;
  wire        rx_push  = rx_strobe && !rx_full;
  wire        rx_pop   = rd_data && rx_cnt != '0;
  wire [10:0] rx_head  = rx_mem[rx_rp];
  wire [2:0]  head_err = (rx_cnt != '0) ? rx_head[10:8] : 3'b000;
  wire [2:0]  in_err   = {rx_brk, rx_ferr, rx_perr};
  wire        bad_in   = rx_push && |in_err;
  wire        bad_out  = rx_pop && |head_err;

  wire tx_push = wr_data && tx_cnt != FULL;
  wire tx_pop  = tx_pull && tx_cnt != '0;

  always_comb begin
    case (trig_sel)
      2'b00:   trig = CW'(1);
      2'b01:   trig = CW'(TRIG_B);
      2'b10:   trig = CW'(TRIG_C);
      default: trig = CW'(TRIG_D);
    endcase
    if (!fifo_en) trig = CW'(1);
  end

  wire [7:0] lsr = {err_cnt != '0, tx_cnt == '0 && !tx_busy, tx_cnt == '0,
                    head_err, ovr, rx_cnt != '0};

  wire src_ls = ier[2] && (ovr || |head_err);
  wire src_rx = ier[0] && rx_cnt >= trig;
  wire src_tx = ier[1] && tx_flag;

  always_comb begin
    if (src_ls)      isr_code = 4'b0110;
    else if (src_rx) isr_code = 4'b0100;
    else if (src_tx) isr_code = 4'b0010;
    else             isr_code = 4'b0001;
  end

  assign irq      = ~isr_code[0];
  assign tx_byte  = tx_mem[tx_rp];
  assign tx_valid = tx_cnt != '0;

  always_comb begin
    case (cpu_addr)
      A_DATA:  cpu_rdata = (rx_cnt != '0) ? rx_head[7:0] : 8'h00;
      A_IER:   cpu_rdata = {4'b0000, ier};
      A_ISR:   cpu_rdata = {fifo_en, fifo_en, 2'b00, isr_code};
      A_LSR:   cpu_rdata = lsr;
      default: cpu_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rx_push) rx_mem[rx_wp] <= {in_err, rx_byte};
    if (tx_push) tx_mem[tx_wp] <= cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0; err_cnt <= '0;
    end else if (rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0; err_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      case ({rx_push, rx_pop})
        2'b10:   rx_cnt <= rx_cnt + 1'b1;
        2'b01:   rx_cnt <= rx_cnt - 1'b1;
        default: rx_cnt <= rx_cnt;
      endcase
      case ({bad_in, bad_out})
        2'b10:   err_cnt <= err_cnt + 1'b1;
        2'b01:   err_cnt <= err_cnt - 1'b1;
        default: err_cnt <= err_cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      case ({tx_push, tx_pop})
        2'b10:   tx_cnt <= tx_cnt + 1'b1;
        2'b01:   tx_cnt <= tx_cnt - 1'b1;
        default: tx_cnt <= tx_cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier <= '0; fifo_en <= 1'b0; trig_sel <= 2'b00; ovr <= 1'b0; tx_flag <= 1'b0;
    end else begin
      if (wr_ier) ier <= cpu_wdata[3:0];
      if (wr_fcr) begin
        fifo_en  <= cpu_wdata[0];
        trig_sel <= cpu_wdata[7:6];
      end
      if (rx_strobe && rx_full) ovr <= 1'b1;
      else if (rd_lsr)          ovr <= 1'b0;
      if (tx_pop && tx_cnt == CW'(1) && !tx_push)        tx_flag <= 1'b1;
      else if (wr_data || (rd_isr && isr_code == 4'b0010)) tx_flag <= 1'b0;
    end
  end
endmodule

module uart_fifo_irq_ctrl_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic [7:0]    lsr,
  input logic [3:0]    isr_code,
  input logic [3:0]    ier,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] trig,
  input logic          rx_strobe,
  input logic          rx_flush,
  input logic          wr_data
);
  assert_rx_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[0] && rx_cnt >= trig) |-> irq);
  assert_rx_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && !rx_flush) |=> lsr[0]);
  assert_overrun_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && rx_cnt == CW'(DEPTH)) |=> lsr[1]);
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));
  assert_tx_write_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> isr_code != 4'b0010);
  assert_temt_implies_thre_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> lsr[5]);
  assert_line_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[2] && lsr[1]) |-> isr_code == 4'b0110);
  assert_polled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 4'b0000) |-> !irq);
endmodule

bind uart_fifo_irq_ctrl uart_fifo_irq_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .lsr(lsr), .isr_code(isr_code),
  .ier(ier), .rx_cnt(rx_cnt), .trig(trig), .rx_strobe(rx_strobe),
  .rx_flush(rx_flush), .wr_data(wr_data)
);

// File: tb/tb_uart_fifo_irq_ctrl.sv
module tb_uart_fifo_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [2:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata, rx_byte = 0, tx_byte;
  logic rx_strobe = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
  logic tx_pull = 0, tx_busy = 0, tx_valid, irq;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_rx[$];
  logic [7:0] exp_tx[$];

  always #5 clk = ~clk;

  uart_fifo_irq_ctrl dut (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic reg_wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #1 cpu_wr = 0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cpu_rd = 1; cpu_addr = a;
    #1 d = cpu_rdata;
    @(posedge clk); #1 cpu_rd = 0;
  endtask

  task automatic reg_chk(string req, logic [2:0] a, logic [7:0] exp);
    logic [7:0] d;
    reg_rd(a, d);
    chk(req, d, exp);
  endtask

  // driver: the expected byte enters the scoreboard if the queue has room
  task automatic rx_in(logic [7:0] b, logic [2:0] err);
    @(negedge clk); rx_strobe = 1; rx_byte = b; {rx_brk, rx_ferr, rx_perr} = err;
    if (exp_rx.size() < 16) exp_rx.push_back(b);
    @(posedge clk); #1 rx_strobe = 0; {rx_brk, rx_ferr, rx_perr} = 3'b000;
  endtask

  // monitor side: each byte read out is compared with the scoreboard head
  task automatic rx_out(string req);
    logic [7:0] d, e;
    e = exp_rx.pop_front();
    reg_rd(3'd0, d);
    chk(req, d, e);
  endtask

  task automatic tx_wr(logic [7:0] b);
    exp_tx.push_back(b);
    reg_wr(3'd0, b);
  endtask

  task automatic tx_take();
    logic [7:0] e;
    e = exp_tx.pop_front();
    @(negedge clk);
    chk("R11 tx_valid", tx_valid, 1);
    chk("R11 tx_byte", tx_byte, e);
    tx_pull = 1;
    @(posedge clk); #1 tx_pull = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0);
    reg_chk("R1 ier", 3'd1, 8'h00);
    reg_chk("R1 isr", 3'd2, 8'h01);
    reg_chk("R1 lsr", 3'd3, 8'h60);

    // R2/R3/R4 trigger 4
    reg_wr(3'd2, 8'h41);
    reg_wr(3'd1, 8'h01);
    for (int i = 0; i < 3; i++) rx_in(8'h10 + 8'(i), 3'b000);
    chk("R2 below level 4", irq, 0);
    rx_in(8'h13, 3'b000);
    chk("R2 at level 4", irq, 1);
    reg_chk("R2 isr rx code", 3'd2, 8'hC4);
    rx_out("R4 order");
    chk("R3 self clear", irq, 0);
    reg_chk("R4 lsr data", 3'd3, 8'h61);
    for (int i = 0; i < 3; i++) rx_out("R4 order");
    reg_chk("R4 lsr empty", 3'd3, 8'h60);

    // R2/R5 trigger 14 and overrun
    reg_wr(3'd2, 8'hC1);
    for (int i = 0; i < 13; i++) rx_in(8'h20 + 8'(i), 3'b000);
    chk("R2 below level 14", irq, 0);
    rx_in(8'h2D, 3'b000);
    chk("R2 at level 14", irq, 1);
    rx_in(8'h2E, 3'b000);
    rx_in(8'h2F, 3'b000);
    rx_in(8'hEE, 3'b000);
    reg_chk("R5 overrun set", 3'd3, 8'h63);
    reg_chk("R5 overrun cleared", 3'd3, 8'h61);
    for (int i = 0; i < 16; i++) rx_out("R5 discarded byte absent");
    reg_chk("R5 lsr drained", 3'd3, 8'h60);

    // R2 trigger 8, R12 rx flush, R2 trigger 1
    reg_wr(3'd2, 8'h81);
    for (int i = 0; i < 7; i++) rx_in(8'h30 + 8'(i), 3'b000);
    chk("R2 below level 8", irq, 0);
    rx_in(8'h37, 3'b000);
    chk("R2 at level 8", irq, 1);
    reg_wr(3'd2, 8'h83);
    exp_rx.delete();
    chk("R12 flush irq", irq, 0);
    reg_chk("R12 rx flushed", 3'd3, 8'h60);
    reg_wr(3'd2, 8'h01);
    rx_in(8'h5A, 3'b000);
    chk("R2 level 1", irq, 1);
    rx_out("R4 single byte");
    chk("R3 level 1 clear", irq, 0);

    // R6 error flags
    reg_wr(3'd1, 8'h00);
    rx_in(8'h11, 3'b000);
    rx_in(8'h22, 3'b001);
    reg_chk("R6 good head, error stored", 3'd3, 8'hE1);
    rx_out("R6 byte");
    reg_chk("R6 parity head", 3'd3, 8'hE5);
    rx_out("R6 byte");
    reg_chk("R6 errors gone", 3'd3, 8'h60);
    rx_in(8'h33, 3'b110);
    reg_chk("R6 framing and break", 3'd3, 8'hF9);
    reg_wr(3'd1, 8'h05);
    reg_chk("R9 line status first", 3'd2, 8'hC6);
    reg_wr(3'd1, 8'h01);
    reg_chk("R9 rx next", 3'd2, 8'hC4);
    rx_out("R6 byte");
    reg_chk("R9 none", 3'd2, 8'hC1);

    // R7/R8/R11 transmit
    reg_wr(3'd1, 8'h02);
    tx_wr(8'hA1); tx_wr(8'hA2); tx_wr(8'hA3);
    reg_chk("R8 tx not empty", 3'd3, 8'h00);
    for (int i = 0; i < 3; i++) tx_take();
    @(negedge clk);
    chk("R7 tx empty irq", irq, 1);
    chk("R11 tx_valid low", tx_valid, 0);
    reg_chk("R8 all empty", 3'd3, 8'h60);
    tx_busy = 1;
    reg_chk("R8 shifter busy", 3'd3, 8'h20);
    tx_busy = 0;
    reg_chk("R7 isr tx code", 3'd2, 8'hC2);
    chk("R7 isr read clear", irq, 0);
    reg_chk("R7 isr after clear", 3'd2, 8'hC1);
    tx_wr(8'hB1);
    tx_take();
    @(negedge clk);
    chk("R7 set again", irq, 1);
    tx_wr(8'hB2);
    chk("R7 write clear", irq, 0);
    tx_take();
    @(negedge clk);
    chk("R7 set third", irq, 1);
    reg_wr(3'd1, 8'h03);
    rx_in(8'h44, 3'b000);
    reg_chk("R9 rx over tx", 3'd2, 8'hC4);
    rx_out("R9 byte");
    chk("R9 tx still pending", irq, 1);
    reg_chk("R9 tx shown", 3'd2, 8'hC2);
    chk("R7 cleared by read", irq, 0);

    // R10 polled mode, R12 flushes
    reg_wr(3'd1, 8'h00);
    for (int i = 0; i < 17; i++) rx_in(8'h60 + 8'(i), 3'b000);
    chk("R10 no irq", irq, 0);
    tx_wr(8'hC1);
    tx_take();
    @(negedge clk);
    chk("R10 no tx irq", irq, 0);
    reg_chk("R10 lsr updates", 3'd3, 8'h63);
    rx_out("R10 polled read");
    reg_chk("R10 overrun cleared", 3'd3, 8'h61);
    reg_wr(3'd2, 8'h03);
    exp_rx.delete();
    reg_chk("R12 rx flushed polled", 3'd3, 8'h60);
    tx_wr(8'hD1); tx_wr(8'hD2);
    reg_wr(3'd2, 8'h05);
    exp_tx.delete();
    @(negedge clk);
    chk("R12 tx flushed", tx_valid, 0);
    reg_chk("R12 tx empty bits", 3'd3, 8'h60);
    finish_up();
  end
endmodule